// File: doc/BRIEF.md
# Single-Channel DMA Engine with Selectable Bus Ownership

This block moves a programmed block of data without the CPU touching each item. Software fills in a memory address, an optional source address, a unit count and a control word through a small register port. Writing the control word with its start bit set launches the transfer. The engine can move data from a peripheral port into memory, from memory out to the peripheral port, or from one memory region to another. Each unit is either one byte or one word.

The engine does not own the memory bus. It raises a bus request and drives addresses and strobes only after the CPU answers with a bus grant. When it is done with the bus it withdraws the request, and it waits for the grant to fall before it asks again.

Three ownership policies are available:
- Burst keeps the bus for the whole block, or for a programmed number of units per tenure.
- Cycle stealing hands the bus back after every unit.
- Transparent starts a unit only in a cycle in which the CPU reports that it is not using the bus.

When the last unit has moved, a sticky completion flag drives the interrupt line.

Top module: `dmac_top`

## Requirements
- R1: After reset, every register reads zero and both the bus request and the interrupt are low. Register selector values: 0 is the memory address, 1 the source address, 2 the remaining count, 3 control, 4 status (bit 0 busy, bit 1 done). Each register reads back the value last written to it.
- R2: Control bit layout:
  - bits [1:0] pick the direction: 0 is peripheral to memory, 1 is memory to peripheral, 2 is memory to memory.
  - bits [3:2] pick the policy: 0 is burst, 1 is cycle stealing, 2 is transparent.
  - bit 4 selects word units.
  - bits [7:5] give the number of burst units per tenure, where 0 means the whole block.
  - bit 8 starts the transfer and always reads back as 0.
- R3: After each unit, the memory address advances by 1 in byte mode and by 2 in word mode. In memory-to-memory transfers the source address advances by the same step. The count falls by one per unit and ends at zero.
- R4: Memory and peripheral strobes occur only while the bus grant is high, and only after the engine has raised its bus request.
- R5: In burst mode with a burst length of 0, the request stays high from the first unit to the last (one tenure). With a burst length of k, the block takes ceil(count/k) tenures.
- R6: In cycle-stealing mode, the engine releases the request after every unit, so a block of N units takes N tenures.
- R7: In transparent mode, a unit is launched only on a clock edge at which the CPU-idle input is high. While that input stays low, the engine never raises its request.
- R8: In memory-to-memory mode, each unit is a read at the source address followed in the very next cycle by a write of that data to the memory address. A unit already begun completes even if CPU-idle falls in between.
- R9: Data paths:
  - Peripheral to memory: each unit is one cycle with the peripheral read strobe and the memory write strobe, and the peripheral data is written.
  - Memory to peripheral: the memory read strobe and the peripheral write strobe occur together, and the memory data is passed to the peripheral.
  - Byte mode: the upper byte of all outgoing data is zero.
- R10: When the final unit completes, the done bit and the interrupt go high. They stay high until status is written with bit 1 set. Writing 0 to that bit leaves them set.
- R11: Starting with a count of zero does nothing: busy stays low, no request is raised, and no interrupt occurs.
- R12: While busy, writes to the address, source, count and control registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register selector |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| bus_req | output | 1 | Request for the memory bus |
| bus_grant | input | 1 | Grant of the memory bus from the CPU |
| cpu_idle | input | 1 | CPU reports it is not using the bus this cycle |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_word | output | 1 | Access is a word (1) or a byte (0) |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid in the strobe cycle |
| pio_rd | output | 1 | Peripheral read strobe |
| pio_rdata | input | DATA_W | Peripheral read data |
| pio_wr | output | 1 | Peripheral write strobe |
| pio_wdata | output | DATA_W | Peripheral write data |
| irq | output | 1 | Block-complete interrupt (level) |

## Verification
The bench sweeps every direction, every policy and both unit sizes over several block lengths. It predicts the address, data and cycle of every strobe and the exact number of bus tenures.

Each check targets a specific class of bug:
- A wrong step size or a source pointer that does not advance shows up as an address mismatch.
- A burst that releases early, or a stealing engine that keeps the bus, changes the tenure count.
- A transparent engine that launches on a busy cycle, or that aborts a half-done memory-to-memory unit, is caught by the idle-edge and read-write adjacency checks.
- An engine that still takes register writes while busy, or that starts on a zero count, or an interrupt flag that clears on a zero write, is caught by reading the registers and the interrupt pin back afterwards.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [1:0] {
    DIR_P2M = 2'd0,
    DIR_M2P = 2'd1,
    DIR_M2M = 2'd2
  } dir_e;

  typedef enum logic [1:0] {
    MODE_BURST  = 2'd0,
    MODE_STEAL  = 2'd1,
    MODE_TRANSP = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RD,
    ST_XF,
    ST_REL
  } st_e;

  localparam int BLEN_W = 3;

  // control word, LSB first: dir, mode, word, blen
  typedef struct packed {
    logic [BLEN_W-1:0] blen;
    logic              word;
    mode_e             mode;
    dir_e              dir;
  } cfg_t;

  localparam int CFG_W     = $bits(cfg_t);
  localparam int START_BIT = CFG_W;
  localparam int DONE_BIT  = 1;

  localparam logic [2:0] SEL_DST  = 3'd0;
  localparam logic [2:0] SEL_SRC  = 3'd1;
  localparam logic [2:0] SEL_CNT  = 3'd2;
  localparam logic [2:0] SEL_CTRL = 3'd3;
  localparam logic [2:0] SEL_STAT = 3'd4;

  // address increment per unit
  function automatic logic [7:0] step_of(input logic word, input int unsigned bytes_per_word);
    return word ? 8'(bytes_per_word) : 8'd1;
  endfunction

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              unit_done,
  output cfg_t              cfg,
  output logic [ADDR_W-1:0] dst,
  output logic [ADDR_W-1:0] src,
  output logic [CNT_W-1:0]  cnt,
  output logic              busy,
  output logic              done_flag
);

  localparam int WORD_BYTES = DATA_W / 8;

  logic              wr_dst, wr_src, wr_cnt, wr_ctrl;
  logic              start_req, last_unit, clr_done;
  logic [ADDR_W-1:0] step_a;

  assign wr_dst    = reg_wr && (reg_sel == SEL_DST)  && !busy;
  assign wr_src    = reg_wr && (reg_sel == SEL_SRC)  && !busy;
  assign wr_cnt    = reg_wr && (reg_sel == SEL_CNT)  && !busy;
  assign wr_ctrl   = reg_wr && (reg_sel == SEL_CTRL) && !busy;
  assign start_req = wr_ctrl && reg_wdata[START_BIT];
  assign last_unit = unit_done && (cnt == CNT_W'(1));
  assign clr_done  = reg_wr && (reg_sel == SEL_STAT) && reg_wdata[DONE_BIT];
  assign step_a    = ADDR_W'(step_of(cfg.word, WORD_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst       <= '0;
      src       <= '0;
      cnt       <= '0;
      cfg       <= '0;
      busy      <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      if (wr_dst)         dst <= reg_wdata[ADDR_W-1:0];
      else if (unit_done) dst <= dst + step_a;

      if (wr_src)                                src <= reg_wdata[ADDR_W-1:0];
      else if (unit_done && cfg.dir == DIR_M2M)  src <= src + step_a;

      if (wr_cnt)         cnt <= reg_wdata[CNT_W-1:0];
      else if (unit_done) cnt <= cnt - CNT_W'(1);

      if (wr_ctrl) cfg <= cfg_t'(reg_wdata[CFG_W-1:0]);

      if (start_req && cnt != '0) busy <= 1'b1;
      else if (last_unit)         busy <= 1'b0;

      if (last_unit)     done_flag <= 1'b1;
      else if (clr_done) done_flag <= 1'b0;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_DST:  reg_rdata = DATA_W'(dst);
      SEL_SRC:  reg_rdata = DATA_W'(src);
      SEL_CNT:  reg_rdata = DATA_W'(cnt);
      SEL_CTRL: reg_rdata = DATA_W'(cfg);
      SEL_STAT: reg_rdata = DATA_W'({done_flag, busy});
      default:  reg_rdata = '0;
    endcase
  end

  // R12: the count holds while busy unless a unit completes
  assert_busy_lock_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_sel == SEL_CNT && !unit_done) |=> (cnt == $past(cnt)));

  // R10: done flag is sticky until a one is written to it
  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !(reg_wr && reg_sel == SEL_STAT && reg_wdata[DONE_BIT])) |=> done_flag);

  // R10: finishing the last unit raises done and drops busy
  assert_finish_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && cnt == CNT_W'(1)) |=> (done_flag && !busy));

  // R11: a start with a zero count leaves the engine idle
  assert_zero_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_wr && reg_sel == SEL_CTRL && reg_wdata[START_BIT] && cnt == '0) |=> !busy);

endmodule

// File: rtl/dmac_fsm.sv
module dmac_fsm
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg,
  input  logic              busy,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [ADDR_W-1:0] dst,
  input  logic [ADDR_W-1:0] src,
  input  logic              bus_grant,
  input  logic              cpu_idle,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] pio_rdata,
  output logic              bus_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_word,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              pio_rd,
  output logic              pio_wr,
  output logic [DATA_W-1:0] pio_wdata,
  output logic              unit_done
);

  function automatic logic [DATA_W-1:0] lane(input logic word, input logic [DATA_W-1:0] d);
    return word ? d : {{(DATA_W-8){1'b0}}, d[7:0]};
  endfunction

  st_e               state, nxt;
  logic [BLEN_W-1:0] ten_cnt;
  logic [DATA_W-1:0] hold_q;
  logic              last, may_start, tenure_full, active, unit_launch;
  st_e               first_st;

  assign last        = (cnt == CNT_W'(1));
  assign may_start   = (cfg.mode != MODE_TRANSP) || cpu_idle;
  assign first_st    = (cfg.dir == DIR_M2M) ? ST_RD : ST_XF;
  assign tenure_full = (cfg.mode == MODE_STEAL) ||
                       (cfg.mode == MODE_BURST && cfg.blen != '0 &&
                        ({1'b0, ten_cnt} + 1'b1) == {1'b0, cfg.blen});
  assign active      = bus_grant && (state == ST_RD || state == ST_XF);
  assign unit_done   = bus_grant && (state == ST_XF);

  always_comb begin
    nxt         = state;
    unit_launch = 1'b0;
    case (state)
      ST_IDLE: if (busy && may_start) nxt = ST_REQ;
      ST_REQ: begin
        if (!busy || cnt == '0) nxt = ST_REL;
        else if (bus_grant && may_start) begin
          nxt         = first_st;
          unit_launch = 1'b1;
        end
      end
      ST_RD: if (bus_grant) nxt = ST_XF;
      ST_XF: begin
        if (bus_grant) begin
          if (last || tenure_full || !may_start) nxt = ST_REL;
          else begin
            nxt         = first_st;
            unit_launch = 1'b1;
          end
        end
      end
      ST_REL:  if (!bus_grant) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ten_cnt <= '0;
      hold_q  <= '0;
    end else begin
      state <= nxt;
      if (state == ST_REQ)  ten_cnt <= '0;
      else if (unit_done)   ten_cnt <= ten_cnt + 1'b1;
      if (state == ST_RD && bus_grant) hold_q <= mem_rdata;
    end
  end

  assign bus_req   = (state == ST_REQ) || (state == ST_RD) || (state == ST_XF);
  assign mem_rd    = active && (state == ST_RD || cfg.dir == DIR_M2P);
  assign mem_wr    = active && (state == ST_XF) && (cfg.dir != DIR_M2P);
  assign pio_rd    = active && (state == ST_XF) && (cfg.dir == DIR_P2M);
  assign pio_wr    = active && (state == ST_XF) && (cfg.dir == DIR_M2P);
  assign mem_addr  = (state == ST_RD) ? src : dst;
  assign mem_word  = cfg.word;
  assign mem_wdata = lane(cfg.word, (cfg.dir == DIR_P2M) ? pio_rdata : hold_q);
  assign pio_wdata = lane(cfg.word, mem_rdata);

  // R4: a strobe is always preceded by a raised request
  assert_strobe_after_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> $past(bus_req));

  // R6: cycle stealing gives the bus back after each unit
  assert_steal_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && cfg.mode == MODE_STEAL) |=> !bus_req);

  // R5: an unlimited burst keeps the bus between units
  assert_burst_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && cfg.mode == MODE_BURST && cfg.blen == '0 && !last) |=> bus_req);

  // R7: transparent units start only on idle cycles
  assert_transp_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_launch && cfg.mode == MODE_TRANSP) |-> cpu_idle);

  // R8: a granted read phase is followed by its write phase
  assert_m2m_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD && bus_grant) |=> (state == ST_XF));

endmodule

// File: rtl/dmac_top.sv
module dmac_top
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              bus_req,
  input  logic              bus_grant,
  input  logic              cpu_idle,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_word,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              pio_rd,
  input  logic [DATA_W-1:0] pio_rdata,
  output logic              pio_wr,
  output logic [DATA_W-1:0] pio_wdata,
  output logic              irq
);

  cfg_t              cfg;
  logic [ADDR_W-1:0] dst, src;
  logic [CNT_W-1:0]  cnt;
  logic              busy, done_flag, unit_done;

  dmac_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .unit_done(unit_done),
    .cfg(cfg), .dst(dst), .src(src), .cnt(cnt), .busy(busy), .done_flag(done_flag)
  );

  dmac_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .busy(busy), .cnt(cnt), .dst(dst), .src(src),
    .bus_grant(bus_grant), .cpu_idle(cpu_idle), .mem_rdata(mem_rdata),
    .pio_rdata(pio_rdata), .bus_req(bus_req), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_word(mem_word), .mem_wdata(mem_wdata), .pio_rd(pio_rd),
    .pio_wr(pio_wr), .pio_wdata(pio_wdata), .unit_done(unit_done)
  );

  assign irq = done_flag;

  // R4: strobes only while granted
  assert_grant_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr || pio_rd || pio_wr) |-> bus_grant);

endmodule

// File: tb/dmac_top_bench.sv
module dmac_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [2:0]  reg_sel = 0;
  logic        reg_wr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic        bus_req, bus_grant = 0, cpu_idle = 1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, pio_rdata, pio_wdata;
  logic        mem_rd, mem_wr, mem_word, pio_rd, pio_wr, irq;

  int checks = 0, errors = 0;
  int idle_mode = 0;              // 0 always idle, 1 idle one cycle in four, 2 never idle
  int cyc = 0, ten = 0, gviol = 0, tviol = 0;
  logic prev_br = 0;
  logic [15:0] pio_seq = 0;
  int lg_n = 0;
  int lg_kind [64];
  logic [15:0] lg_addr [64];
  logic [15:0] lg_data [64];
  int lg_cyc [64];
  int cur_dir, cur_mode, cur_word, cur_blen, cur_n;
  logic [15:0] cur_dst, cur_src, cur_base;

  function automatic logic [15:0] memf(input logic [15:0] a);
    return 16'h9A00 ^ (a * 16'd7);
  endfunction

  function automatic logic [15:0] lanef(input int word, input logic [15:0] d);
    return (word != 0) ? d : (d & 16'h00FF);
  endfunction

  assign mem_rdata = memf(mem_addr);
  assign pio_rdata = 16'hC300 + pio_seq;

  dmac_top u_dmac_top (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_req(bus_req), .bus_grant(bus_grant), .cpu_idle(cpu_idle),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_word(mem_word),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pio_rd(pio_rd), .pio_rdata(pio_rdata),
    .pio_wr(pio_wr), .pio_wdata(pio_wdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // CPU grants one cycle after the request; peripheral source advances per read
  always @(posedge clk) begin
    bus_grant <= rst_n ? bus_req : 1'b0;
    if (pio_rd) pio_seq <= pio_seq + 16'd1;
  end

  // monitor mid-cycle, then set the idle level for the next cycle
  always @(negedge clk) begin
    logic first;
    cyc++;
    if (bus_req && !prev_br) ten++;
    prev_br = bus_req;
    if ((mem_rd || mem_wr || pio_rd || pio_wr) && !bus_grant) gviol++;
    first = (cur_dir == 2) ? mem_rd : (mem_wr || pio_wr);
    if (first && !cpu_idle) tviol++;
    if (lg_n < 64 && (pio_wr || mem_wr || mem_rd)) begin
      lg_kind[lg_n] = pio_wr ? 2 : (mem_wr ? 1 : 0);
      lg_addr[lg_n] = mem_addr;
      lg_data[lg_n] = pio_wr ? pio_wdata : (mem_wr ? mem_wdata : 16'h0);
      lg_cyc[lg_n]  = cyc;
      lg_n++;
    end
    cpu_idle = (idle_mode == 0) ? 1'b1 : (idle_mode == 1) ? ((cyc % 4) == 0) : 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    reg_sel = 3'(sel); reg_wdata = 16'(data); reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input int sel, output int data);
    @(negedge clk);
    reg_sel = 3'(sel);
    #1 data = int'(reg_rdata);
  endtask

  task automatic run_start(input int dir, input int mode, input int word, input int blen,
                           input int n, input int dst0, input int src0);
    cur_dir = dir; cur_mode = mode; cur_word = word; cur_blen = blen; cur_n = n;
    cur_dst = 16'(dst0); cur_src = 16'(src0);
    wr(0, dst0); wr(1, src0); wr(2, n);
    lg_n = 0; ten = 0; gviol = 0; tviol = 0;
    cur_base = pio_seq;
    wr(3, 256 | (blen << 5) | (word << 4) | (mode << 2) | dir);
  endtask

  task automatic run_check(input int exp_ten);
    int v, step, got_irq;
    logic [15:0] a, sa;
    bit ok;
    step = (cur_word != 0) ? 2 : 1;
    got_irq = 0;
    for (int k = 0; k < 3000 && !got_irq; k++) begin
      @(negedge clk);
      if (irq) got_irq = 1;
    end
    chk(got_irq == 1, "R10", "irq after block", got_irq, 1);
    repeat (6) @(negedge clk);
    chk(lg_n == ((cur_dir == 2) ? 2 * cur_n : cur_n), "R9", "strobe count", lg_n, cur_n);
    for (int i = 0; i < cur_n && lg_n >= ((cur_dir == 2) ? 2 * cur_n : cur_n); i++) begin
      a  = cur_dst + 16'(i * step);
      sa = cur_src + 16'(i * step);
      if (cur_dir == 0) begin
        ok = lg_kind[i] == 1 && lg_addr[i] == a && lg_data[i] == lanef(cur_word, 16'hC300 + cur_base + 16'(i));
        chk(ok, "R9", "p2m unit addr/data", int'({lg_addr[i], lg_data[i]}),
            int'({a, lanef(cur_word, 16'hC300 + cur_base + 16'(i))}));
      end else if (cur_dir == 1) begin
        ok = lg_kind[i] == 2 && lg_addr[i] == a && lg_data[i] == lanef(cur_word, memf(a));
        chk(ok, "R9", "m2p unit addr/data", int'({lg_addr[i], lg_data[i]}),
            int'({a, lanef(cur_word, memf(a))}));
      end else begin
        ok = lg_kind[2*i] == 0 && lg_addr[2*i] == sa && lg_kind[2*i+1] == 1 &&
             lg_addr[2*i+1] == a && lg_data[2*i+1] == lanef(cur_word, memf(sa));
        chk(ok, "R8", "m2m unit read/write", int'({lg_addr[2*i+1], lg_data[2*i+1]}),
            int'({a, lanef(cur_word, memf(sa))}));
        chk(lg_cyc[2*i+1] == lg_cyc[2*i] + 1, "R8", "m2m write follows read",
            lg_cyc[2*i+1] - lg_cyc[2*i], 1);
      end
    end
    rd(0, v); chk(v == int'(cur_dst + 16'(cur_n * step)), "R3", "final address", v, int'(cur_dst + 16'(cur_n * step)));
    rd(2, v); chk(v == 0, "R3", "final count", v, 0);
    if (cur_dir == 2) begin
      rd(1, v); chk(v == int'(cur_src + 16'(cur_n * step)), "R3", "final source", v, int'(cur_src + 16'(cur_n * step)));
    end
    rd(3, v);
    chk(v == ((cur_blen << 5) | (cur_word << 4) | (cur_mode << 2) | cur_dir), "R2", "control readback",
        v, (cur_blen << 5) | (cur_word << 4) | (cur_mode << 2) | cur_dir);
    if (exp_ten >= 0)
      chk(ten == exp_ten, (cur_mode == 1) ? "R6" : "R5", "tenure count", ten, exp_ten);
    chk(gviol == 0, "R4", "strobe without grant", gviol, 0);
    chk(tviol == 0, "R7", "unit launched on busy CPU cycle", tviol, 0);
    rd(4, v); chk(v == 2, "R10", "status done", v, 2);
    wr(4, 0); @(negedge clk);
    chk(irq == 1, "R10", "irq survives zero write", int'(irq), 1);
    wr(4, 2); @(negedge clk);
    chk(irq == 0, "R10", "irq cleared by one", int'(irq), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    cur_dir = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state and plain readback
    for (int s = 0; s < 5; s++) begin
      rd(s, v); chk(v == 0, "R1", "reset register value", v, 0);
    end
    chk(bus_req == 0 && irq == 0, "R1", "reset request/irq", int'({bus_req, irq}), 0);
    wr(0, 16'h1234); wr(1, 16'h0ABC); wr(2, 7);
    rd(0, v); chk(v == 16'h1234, "R1", "address readback", v, 16'h1234);
    rd(1, v); chk(v == 16'h0ABC, "R1", "source readback", v, 16'h0ABC);
    rd(2, v); chk(v == 7, "R1", "count readback", v, 7);

    // R11: zero count start
    wr(2, 0); ten = 0;
    wr(3, 256 | 4 | 1);
    repeat (10) @(negedge clk);
    rd(4, v); chk(v == 0, "R11", "status after zero start", v, 0);
    chk(ten == 0, "R11", "no request on zero count", ten, 0);
    chk(irq == 0, "R11", "no irq on zero count", int'(irq), 0);

    // sweep: direction x policy x unit size x length
    for (int d = 0; d < 3; d++)
      for (int m = 0; m < 3; m++)
        for (int w = 0; w < 2; w++)
          for (int ni = 0; ni < 3; ni++) begin
            int n;
            n = 1 + 2 * ni;
            if (m == 0) begin
              run_start(d, 0, w, 0, n, 16'h0100 + 32 * d + 8 * ni, 16'h0800 + 4 * w);
              run_check(1);
              run_start(d, 0, w, 2, n, 16'h0200 + 32 * d + 8 * ni, 16'h0900);
              run_check((n + 1) / 2);
            end else if (m == 1) begin
              run_start(d, 1, w, 3, n, 16'h0300 + 32 * d, 16'h0A00 + 16 * ni);
              run_check(n);
            end else begin
              run_start(d, 2, w, 0, n, 16'h0500 + 32 * d, 16'h0B00);
              run_check(1);
            end
          end

    // R7: transparent engine stays off the bus while the CPU is busy
    idle_mode = 2;
    repeat (2) @(negedge clk);
    run_start(0, 2, 1, 0, 3, 16'h0600, 0);
    repeat (30) @(negedge clk);
    chk(ten == 0 && bus_req == 0, "R7", "no request while CPU busy", ten, 0);
    rd(4, v); chk(v == 1, "R7", "still busy while CPU busy", v, 1);
    idle_mode = 0;
    run_check(1);

    // R7/R8: sparse idle cycles, memory to memory, idle drops mid-unit
    idle_mode = 1;
    run_start(2, 2, 0, 0, 4, 16'h0700, 16'h0C00);
    run_check(-1);
    idle_mode = 0;

    // R12: writes during a transfer are ignored
    run_start(1, 1, 1, 0, 5, 16'h0400, 0);
    wr(0, 16'h7777); wr(2, 9); wr(3, 0); wr(1, 16'h5555);
    run_check(5);
    rd(0, v); chk(v == 16'h040A, "R12", "address unaffected by busy write", v, 16'h040A);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule